// File: doc/BRIEF.md
# RTC Time Base with Ordered Time Access

This block keeps wall-clock time for a real-time clock. A 32768 Hz enable pulse advances a sub-second counter. When that counter wraps, a 64-bit seconds counter advances. The seconds counter is seen by the host as a low word and a high word. The block itself has no clock-domain crossing: the tick arrives as a single-cycle enable in the block's own clock domain.

Host access goes through a small register port. The time registers must be read and written in a fixed order: sub-second first, then the seconds low word, then the seconds high word.
- **Reads:** reading the sub-second register freezes a copy of both seconds words. The two following reads return that frozen copy, so the three values always belong to the same instant.
- **Writes:** the first two writes are only staged. The whole new time is loaded at once on the high-word write. A sequence broken by any out-of-order access to a time register is thrown away.

Two further registers set up drift compensation:
- an interval register, counted in seconds;
- a control register with an enable bit and an add/drop select.

The new compensation setting is adopted at the next seconds boundary. From then on, after every interval of seconds, the first tick of the next second is either dropped (the tick does not advance time) or doubled (the tick advances time by two).

Top module: `rtc_timebase`

## Requirements
- R1: After reset the sub-second count, the seconds count, both compensation registers and rd_valid_o are zero, and compensation is inactive.
- R2: Each cycle with tick_i high advances the sub-second count by one; with tick_i low and no commit, the sub-second and seconds counts hold.
- R3: A tick when the sub-second count is 32767 sets it to 0 and adds one to the 64-bit seconds count, carrying from the low word into the high word.
- R4: The register addresses are: 0 sub-second, 1 seconds low, 2 seconds high, 3 compensation interval, 4 compensation control. A read returns its data on rd_data_o with rd_valid_o high one cycle later. A read of address 0 returns the live sub-second count and captures both seconds words. Reads of addresses 1 and 2 return the captured words, whatever ticks have occurred since.
- R5: A time write is a write to address 0, then address 1, then address 2. The counts are unchanged after the first two writes. In the cycle after the address 2 write, the sub-second and seconds counts equal the written values; this takes priority over a tick in the same cycle.
- R6: Any access to addresses 0 to 2 other than the next expected write (a read, or a write out of order) clears the staged values, and a later address 2 write then changes nothing. A write to address 0 always starts a new sequence.
- R7: Addresses 3 and 4 read back the last value written to them, and reads of addresses 5 to 7 return zero.
- R8: A compensation control write takes effect only at the next seconds boundary after it. The interval count restarts at that boundary, and no adjustment occurs before it.
- R9: In compensation control, bit 31 enables compensation and bit 30 selects doubling (1) or dropping (0). With compensation enabled and drop selected, every N-th seconds boundary after adoption makes the next tick leave the sub-second count unchanged (N is the interval).
- R10: With compensation enabled and doubling selected, the tick following every N-th seconds boundary advances the sub-second count from 0 to 2.
- R11: An interval of 0 behaves as an interval of 1, and a completed time write cancels an adjustment that is pending but not yet applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32768 Hz time-advance enable, one cycle wide |
| acc_valid_i | input | 1 | Register access strobe |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | 3 | Register address |
| acc_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 32 | Read data |
| sub_cnt_o | output | 15 | Live sub-second count |
| sec_cnt_o | output | 64 | Live seconds count |

## Verification
The hardest state to reach from the ports is an armed compensation adjustment. At the real tick rate it takes N full seconds of 32768 ticks each. The stimulus gets there quickly by committing a time only a few ticks before the end of a second, which crosses a seconds boundary in a handful of cycles. A time commit does not disturb the interval count, so the bench can repeat this to step through adoption and then each interval boundary until the armed tick shows up as a held or doubled sub-second count. Random traffic also mixes broken write sequences, snapshot reads across wraps and compensation writes landing between boundaries, all checked against a cycle model in the bench.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] RA_SUB     = 3'd0;
   localparam logic [ADDR_W-1:0] RA_SEC_LO  = 3'd1;
   localparam logic [ADDR_W-1:0] RA_SEC_HI  = 3'd2;
   localparam logic [ADDR_W-1:0] RA_CMP_IVL = 3'd3;
   localparam logic [ADDR_W-1:0] RA_CMP_CTL = 3'd4;

   typedef enum logic [1:0] {
      WS_IDLE     = 2'd0,
      WS_HAVE_SUB = 2'd1,
      WS_HAVE_LO  = 2'd2
   } wr_state_e;

   function automatic logic is_time_addr(input logic [ADDR_W-1:0] a);
      return (a == RA_SUB) || (a == RA_SEC_LO) || (a == RA_SEC_HI);
   endfunction
endpackage

// File: rtl/rtc_timebase_wr_stage.sv
module rtc_timebase_wr_stage
   import rtc_timebase_pkg::*;
#(
   parameter int SUB_W  = 15,
   parameter int WORD_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [WORD_W-1:0]     acc_wdata,
   output logic                  commit_o,
   output logic [SUB_W-1:0]      c_sub_o,
   output logic [2*WORD_W-1:0]   c_sec_o
);
   wr_state_e          st_q, st_d;
   logic [SUB_W-1:0]   sub_q, sub_d;
   logic [WORD_W-1:0]  lo_q, lo_d;
   logic               hit, in_order;

   always_comb begin
      hit      = acc_valid && is_time_addr(acc_addr);
      st_d     = st_q;
      sub_d    = sub_q;
      lo_d     = lo_q;
      commit_o = 1'b0;
      in_order = 1'b0;
      if (hit) begin
         if (acc_write && acc_addr == RA_SUB) begin
            in_order = 1'b1;
            st_d     = WS_HAVE_SUB;
            sub_d    = acc_wdata[SUB_W-1:0];
            lo_d     = '0;
         end else if (acc_write && acc_addr == RA_SEC_LO && st_q == WS_HAVE_SUB) begin
            in_order = 1'b1;
            st_d     = WS_HAVE_LO;
            lo_d     = acc_wdata;
         end else if (acc_write && acc_addr == RA_SEC_HI && st_q == WS_HAVE_LO) begin
            in_order = 1'b1;
            commit_o = 1'b1;
            st_d     = WS_IDLE;
            sub_d    = '0;
            lo_d     = '0;
         end else begin
            st_d  = WS_IDLE;
            sub_d = '0;
            lo_d  = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WS_IDLE;
         sub_q <= '0;
         lo_q  <= '0;
      end else begin
         st_q  <= st_d;
         sub_q <= sub_d;
         lo_q  <= lo_d;
      end
   end

   assign c_sub_o = sub_q;
   assign c_sec_o = {acc_wdata, lo_q};

   // R6: a broken sequence leaves nothing staged
   a_r6_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !in_order) |=> (st_q == WS_IDLE && sub_q == '0 && lo_q == '0));
   // R5: commit only from the fully staged state
   a_r5_commit_order: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (st_q == WS_HAVE_LO));
endmodule

// File: rtl/rtc_timebase_comp_sched.sv
module rtc_timebase_comp_sched #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ivl,
   input  logic              wr_ctl,
   input  logic [WORD_W-1:0] wdata,
   input  logic              boundary,
   input  logic              adj_done,
   input  logic              commit,
   output logic              armed_o,
   output logic              add_o,
   output logic [WORD_W-1:0] ivl_o,
   output logic [WORD_W-1:0] ctl_o
);
   localparam int EN_BIT  = WORD_W - 1;
   localparam int ADD_BIT = WORD_W - 2;

   logic [WORD_W-1:0] ivl_q, ctl_q, act_ivl_q, cnt_q;
   logic              pend_q, act_en_q, act_add_q, armed_q;
   logic [WORD_W:0]   eff_ivl, cnt_next;
   logic              last;

   always_comb begin
      eff_ivl  = (act_ivl_q == '0) ? (WORD_W+1)'(1) : {1'b0, act_ivl_q};
      cnt_next = {1'b0, cnt_q} + (WORD_W+1)'(1);
      last     = (cnt_next >= eff_ivl);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivl_q     <= '0;
         ctl_q     <= '0;
         act_ivl_q <= '0;
         cnt_q     <= '0;
         pend_q    <= 1'b0;
         act_en_q  <= 1'b0;
         act_add_q <= 1'b0;
         armed_q   <= 1'b0;
      end else begin
         if (wr_ivl) ivl_q <= wdata;
         if (wr_ctl) ctl_q <= wdata;
         if (commit || adj_done) armed_q <= 1'b0;
         if (boundary) begin
            if (pend_q) begin
               act_en_q  <= ctl_q[EN_BIT];
               act_add_q <= ctl_q[ADD_BIT];
               act_ivl_q <= ivl_q;
               cnt_q     <= '0;
            end else if (act_en_q) begin
               if (last) begin
                  armed_q <= 1'b1;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_next[WORD_W-1:0];
               end
            end
         end
         if (wr_ctl)        pend_q <= 1'b1;
         else if (boundary) pend_q <= 1'b0;
      end
   end

   assign armed_o = armed_q;
   assign add_o   = act_add_q;
   assign ivl_o   = ivl_q;
   assign ctl_o   = ctl_q;

   // R8: arming only ever happens at a seconds boundary
   a_r8_arm_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(boundary));
   // R8: a boundary with pending setting never arms in the same step
   a_r8_adopt_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && pend_q && !armed_q) |=> !armed_q);
endmodule

// File: rtl/rtc_timebase_time_core.sv
module rtc_timebase_time_core #(
   parameter int SUB_W  = 15,
   parameter int WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                commit,
   input  logic [SUB_W-1:0]    c_sub,
   input  logic [2*WORD_W-1:0] c_sec,
   input  logic                armed,
   input  logic                arm_add,
   output logic                boundary_o,
   output logic                adj_done_o,
   output logic [SUB_W-1:0]    sub_o,
   output logic [2*WORD_W-1:0] sec_o
);
   localparam int             SEC_W   = 2 * WORD_W;
   localparam logic [SUB_W-1:0] SUB_MAX = '1;

   logic [SUB_W-1:0] sub_q;
   logic [SEC_W-1:0] sec_q;

   assign boundary_o = tick && !commit && !armed && (sub_q == SUB_MAX);
   assign adj_done_o = tick && !commit && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         sec_q <= '0;
      end else if (commit) begin
         sub_q <= c_sub;
         sec_q <= c_sec;
      end else if (tick) begin
         if (armed) begin
            if (arm_add) sub_q <= sub_q + SUB_W'(2);
         end else if (sub_q == SUB_MAX) begin
            sub_q <= '0;
            sec_q <= sec_q + SEC_W'(1);
         end else begin
            sub_q <= sub_q + SUB_W'(1);
         end
      end
   end

   assign sub_o = sub_q;
   assign sec_o = sec_q;

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !commit) |=> ($stable(sub_q) && $stable(sec_q)));
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && !armed && sub_q != SUB_MAX)
      |=> (sub_q == $past(sub_q) + SUB_W'(1) && $stable(sec_q)));
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit && !armed && sub_q == SUB_MAX)
      |=> (sub_q == '0 && sec_q == $past(sec_q) + SEC_W'(1)));
   a_r5_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (sub_q == $past(c_sub) && sec_q == $past(c_sec)));
   a_r9_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_done_o && !arm_add) |=> $stable(sub_q));
   a_r10_add_two: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_done_o && arm_add) |=> (sub_q == $past(sub_q) + SUB_W'(2)));
endmodule

// File: rtl/rtc_timebase_rd_port.sv
module rtc_timebase_rd_port
   import rtc_timebase_pkg::*;
#(
   parameter int SUB_W  = 15,
   parameter int WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [SUB_W-1:0]    live_sub,
   input  logic [2*WORD_W-1:0] live_sec,
   input  logic [WORD_W-1:0]   cmp_ivl,
   input  logic [WORD_W-1:0]   cmp_ctl,
   output logic                rd_valid_o,
   output logic [WORD_W-1:0]   rd_data_o
);
   logic [WORD_W-1:0] snap_lo_q, snap_hi_q, rd_sel;
   logic              rd_req, take_snap;

   assign rd_req    = acc_valid && !acc_write;
   assign take_snap = rd_req && (acc_addr == RA_SUB);

   always_comb begin
      case (acc_addr)
         RA_SUB:     rd_sel = WORD_W'(live_sub);
         RA_SEC_LO:  rd_sel = snap_lo_q;
         RA_SEC_HI:  rd_sel = snap_hi_q;
         RA_CMP_IVL: rd_sel = cmp_ivl;
         RA_CMP_CTL: rd_sel = cmp_ctl;
         default:    rd_sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_lo_q  <= '0;
         snap_hi_q  <= '0;
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_req;
         if (rd_req) rd_data_o <= rd_sel;
         if (take_snap) begin
            snap_lo_q <= live_sec[WORD_W-1:0];
            snap_hi_q <= live_sec[2*WORD_W-1:WORD_W];
         end
      end
   end

   a_r4_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid_o);
   a_r4_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !take_snap |=> ($stable(snap_lo_q) && $stable(snap_hi_q)));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
   import rtc_timebase_pkg::*;
#(
   parameter int SUB_W   = 15,
   parameter int WORD_W  = 32,
   parameter bit COMP_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                acc_valid_i,
   input  logic                acc_write_i,
   input  logic [ADDR_W-1:0]   acc_addr_i,
   input  logic [WORD_W-1:0]   acc_wdata_i,
   output logic                rd_valid_o,
   output logic [WORD_W-1:0]   rd_data_o,
   output logic [SUB_W-1:0]    sub_cnt_o,
   output logic [2*WORD_W-1:0] sec_cnt_o
);
   localparam int SEC_W = 2 * WORD_W;

   if (SUB_W < 2 || SUB_W > WORD_W) begin : g_bad_sub_w
      $error("rtc_timebase: SUB_W must lie between 2 and WORD_W");
   end
   if (WORD_W < 8) begin : g_bad_word_w
      $error("rtc_timebase: WORD_W must be at least 8");
   end

   logic             commit, boundary, adj_done, armed, arm_add;
   logic [SUB_W-1:0] c_sub;
   logic [SEC_W-1:0] c_sec;
   logic [WORD_W-1:0] cmp_ivl, cmp_ctl;
   logic             wr_ivl, wr_ctl;

   assign wr_ivl = acc_valid_i && acc_write_i && (acc_addr_i == RA_CMP_IVL);
   assign wr_ctl = acc_valid_i && acc_write_i && (acc_addr_i == RA_CMP_CTL);

   rtc_timebase_wr_stage #(.SUB_W(SUB_W), .WORD_W(WORD_W)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid_i), .acc_write(acc_write_i),
      .acc_addr(acc_addr_i), .acc_wdata(acc_wdata_i),
      .commit_o(commit), .c_sub_o(c_sub), .c_sec_o(c_sec)
   );

   if (COMP_EN) begin : g_comp
      rtc_timebase_comp_sched #(.WORD_W(WORD_W)) u_comp (
         .clk(clk), .rst_n(rst_n),
         .wr_ivl(wr_ivl), .wr_ctl(wr_ctl), .wdata(acc_wdata_i),
         .boundary(boundary), .adj_done(adj_done), .commit(commit),
         .armed_o(armed), .add_o(arm_add), .ivl_o(cmp_ivl), .ctl_o(cmp_ctl)
      );
   end else begin : g_no_comp
      assign armed   = 1'b0;
      assign arm_add = 1'b0;
      assign cmp_ivl = '0;
      assign cmp_ctl = '0;
   end

   rtc_timebase_time_core #(.SUB_W(SUB_W), .WORD_W(WORD_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick_i),
      .commit(commit), .c_sub(c_sub), .c_sec(c_sec),
      .armed(armed), .arm_add(arm_add),
      .boundary_o(boundary), .adj_done_o(adj_done),
      .sub_o(sub_cnt_o), .sec_o(sec_cnt_o)
   );

   rtc_timebase_rd_port #(.SUB_W(SUB_W), .WORD_W(WORD_W)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid_i), .acc_write(acc_write_i), .acc_addr(acc_addr_i),
      .live_sub(sub_cnt_o), .live_sec(sec_cnt_o),
      .cmp_ivl(cmp_ivl), .cmp_ctl(cmp_ctl),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
   );

   // R9: an armed adjustment always meets the start of a second
   a_r9_armed_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (sub_cnt_o == '0));
   // R11: a time commit cancels any armed adjustment
   a_r11_commit_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !armed);
endmodule

// File: tb/rtc_timebase_tb.sv
module rtc_timebase_tb;
   localparam int SUB_W  = 15;
   localparam int WORD_W = 32;
   localparam logic [SUB_W-1:0] SMAX = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        acc_valid_i = 1'b0;
   logic        acc_write_i = 1'b0;
   logic [2:0]  acc_addr_i = '0;
   logic [31:0] acc_wdata_i = '0;
   logic        rd_valid_o;
   logic [31:0] rd_data_o;
   logic [14:0] sub_cnt_o;
   logic [63:0] sec_cnt_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   rtc_timebase u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
      .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
      .sub_cnt_o(sub_cnt_o), .sec_cnt_o(sec_cnt_o)
   );

   // bench-side cycle model built from the requirements
   logic [14:0] m_sub, m_ssub;
   logic [63:0] m_sec;
   logic [31:0] m_slo, m_snlo, m_snhi, m_ivl, m_ctl, m_aivl, m_cnt, m_rd;
   logic [1:0]  m_st;
   logic        m_pend, m_aen, m_aadd, m_armed, m_rv;

   task automatic model_reset();
      m_sub = '0; m_ssub = '0; m_sec = '0; m_slo = '0; m_snlo = '0; m_snhi = '0;
      m_ivl = '0; m_ctl = '0; m_aivl = '0; m_cnt = '0; m_rd = '0; m_st = '0;
      m_pend = 1'b0; m_aen = 1'b0; m_aadd = 1'b0; m_armed = 1'b0; m_rv = 1'b0;
   endtask

   task automatic model_step(input logic tk, input logic v, input logic w,
                             input logic [2:0] a, input logic [31:0] d);
      logic commit, bnd, adj, last;
      logic [32:0] eff;
      logic [14:0] n_sub;
      logic [63:0] n_sec;
      commit = 1'b0; bnd = 1'b0; adj = 1'b0;
      m_rv = v && !w;
      if (v && !w) begin
         case (a)
            3'd0: m_rd = {17'd0, m_sub};
            3'd1: m_rd = m_snlo;
            3'd2: m_rd = m_snhi;
            3'd3: m_rd = m_ivl;
            3'd4: m_rd = m_ctl;
            default: m_rd = '0;
         endcase
      end
      n_sub = m_sub; n_sec = m_sec;
      if (v && w && a == 3'd2 && m_st == 2'd2) begin
         commit = 1'b1;
         n_sub = m_ssub; n_sec = {d, m_slo};
      end else if (tk) begin
         if (m_armed) begin
            adj = 1'b1;
            if (m_aadd) n_sub = m_sub + 15'd2;
         end else if (m_sub == SMAX) begin
            n_sub = '0; n_sec = m_sec + 64'd1; bnd = 1'b1;
         end else n_sub = m_sub + 15'd1;
      end
      if (v && !w && a == 3'd0) begin
         m_snlo = m_sec[31:0]; m_snhi = m_sec[63:32];
      end
      if (v && a <= 3'd2) begin
         if (w && a == 3'd0) begin m_st = 2'd1; m_ssub = d[14:0]; m_slo = '0; end
         else if (w && a == 3'd1 && m_st == 2'd1) begin m_st = 2'd2; m_slo = d; end
         else begin m_st = 2'd0; m_ssub = '0; m_slo = '0; end
      end
      if (commit || adj) m_armed = 1'b0;
      if (bnd) begin
         if (m_pend) begin
            m_aen = m_ctl[31]; m_aadd = m_ctl[30]; m_aivl = m_ivl; m_cnt = '0;
         end else if (m_aen) begin
            eff  = (m_aivl == 0) ? 33'd1 : {1'b0, m_aivl};
            last = ({1'b0, m_cnt} + 33'd1) >= eff;
            if (last) begin m_armed = 1'b1; m_cnt = '0; end
            else m_cnt = m_cnt + 32'd1;
         end
      end
      if (v && w && a == 3'd4) m_pend = 1'b1;
      else if (bnd) m_pend = 1'b0;
      if (v && w && a == 3'd3) m_ivl = d;
      if (v && w && a == 3'd4) m_ctl = d;
      m_sub = n_sub; m_sec = n_sec;
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cyc(input logic tk, input logic v, input logic w,
                      input logic [2:0] a, input logic [31:0] d, input string tag);
      tick_i = tk; acc_valid_i = v; acc_write_i = w; acc_addr_i = a; acc_wdata_i = d;
      @(posedge clk);
      model_step(tk, v, w, a, d);
      @(negedge clk);
      tick_i = 1'b0; acc_valid_i = 1'b0; acc_write_i = 1'b0;
      chk(tag, "sub_cnt", {49'd0, sub_cnt_o}, {49'd0, m_sub});
      chk(tag, "sec_cnt", sec_cnt_o, m_sec);
      chk(tag, "rd_valid", {63'd0, rd_valid_o}, {63'd0, m_rv});
      if (m_rv) chk(tag, "rd_data", {32'd0, rd_data_o}, {32'd0, m_rd});
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
      cyc(1'b0, 1'b1, 1'b1, a, d, tag);
   endtask

   task automatic rd(input logic [2:0] a, input string tag);
      cyc(1'b0, 1'b1, 1'b0, a, 32'd0, tag);
   endtask

   task automatic set_time(input logic [14:0] s, input logic [31:0] lo,
                           input logic [31:0] hi, input string tag);
      wr(3'd0, {17'd0, s}, tag);
      wr(3'd1, lo, tag);
      wr(3'd2, hi, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "sub", {49'd0, sub_cnt_o}, 64'd0);
      chk("R1", "sec", sec_cnt_o, 64'd0);
      chk("R1", "rd_valid", {63'd0, rd_valid_o}, 64'd0);
      rd(3'd4, "R1");
      chk("R1", "comp ctl", {32'd0, rd_data_o}, 64'd0);
      rd(3'd3, "R1");
      chk("R1", "comp ivl", {32'd0, rd_data_o}, 64'd0);

      // R2 counting and holding
      ticks(5, "R2");
      chk("R2", "five ticks", {49'd0, sub_cnt_o}, 64'd5);
      repeat (4) cyc(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "R2");
      chk("R2", "hold", {49'd0, sub_cnt_o}, 64'd5);

      // R5 staged write, commit on high word; R3 carry into high word
      wr(3'd0, {17'd0, SMAX - 15'd1}, "R5");
      wr(3'd1, 32'hFFFF_FFFF, "R5");
      chk("R5", "staged no change", {49'd0, sub_cnt_o}, 64'd5);
      wr(3'd2, 32'd5, "R5");
      chk("R5", "commit sub", {49'd0, sub_cnt_o}, {49'd0, SMAX - 15'd1});
      chk("R5", "commit sec", sec_cnt_o, 64'h0000_0005_FFFF_FFFF);
      ticks(2, "R3");
      chk("R3", "wrap sub", {49'd0, sub_cnt_o}, 64'd0);
      chk("R3", "carry sec", sec_cnt_o, 64'h0000_0006_0000_0000);

      // R5 commit wins over a tick in the same cycle
      wr(3'd0, 32'd100, "R5");
      wr(3'd1, 32'd7, "R5");
      cyc(1'b1, 1'b1, 1'b1, 3'd2, 32'd0, "R5");
      chk("R5", "commit over tick", {49'd0, sub_cnt_o}, 64'd100);

      // R4 snapshot reads
      set_time(SMAX - 15'd2, 32'hFFFF_FFFF, 32'h0000_0010, "R4");
      rd(3'd0, "R4");
      chk("R4", "live sub", {32'd0, rd_data_o}, {49'd0, SMAX - 15'd2});
      ticks(6, "R4");
      rd(3'd1, "R4");
      chk("R4", "snap lo", {32'd0, rd_data_o}, 64'hFFFF_FFFF);
      rd(3'd2, "R4");
      chk("R4", "snap hi", {32'd0, rd_data_o}, 64'h10);
      chk("R4", "live moved on", sec_cnt_o, 64'h0000_0011_0000_0000);

      // R6 broken sequences are discarded
      set_time(15'd50, 32'd1, 32'd0, "R6");
      wr(3'd0, 32'd9, "R6");
      wr(3'd2, 32'd9, "R6");
      wr(3'd1, 32'd9, "R6");
      wr(3'd2, 32'd9, "R6");
      chk("R6", "out of order ignored", {49'd0, sub_cnt_o}, 64'd50);
      chk("R6", "sec untouched", sec_cnt_o, 64'd1);
      wr(3'd0, 32'd11, "R6");
      rd(3'd0, "R6");
      wr(3'd1, 32'd11, "R6");
      wr(3'd2, 32'd11, "R6");
      chk("R6", "read breaks seq", {49'd0, sub_cnt_o}, 64'd50);
      wr(3'd0, 32'd12, "R6");
      wr(3'd0, 32'd13, "R6");
      wr(3'd1, 32'd3, "R6");
      wr(3'd2, 32'd0, "R6");
      chk("R6", "restart on sub write", {49'd0, sub_cnt_o}, 64'd13);

      // R7 compensation register readback, unmapped reads
      wr(3'd3, 32'd2, "R7");
      wr(3'd4, 32'h8000_0000, "R7");
      rd(3'd3, "R7");
      chk("R7", "ivl", {32'd0, rd_data_o}, 64'd2);
      rd(3'd4, "R7");
      chk("R7", "ctl", {32'd0, rd_data_o}, 64'h8000_0000);
      rd(3'd6, "R7");
      chk("R7", "unmapped", {32'd0, rd_data_o}, 64'd0);

      // R8/R9 drop every 2 seconds
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R8");
      ticks(3, "R8");
      ticks(1, "R8");
      chk("R8", "no adjust at adoption", {49'd0, sub_cnt_o}, 64'd1);
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R8");
      ticks(4, "R8");
      chk("R8", "first interval second", {49'd0, sub_cnt_o}, 64'd1);
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R9");
      ticks(4, "R9");
      chk("R9", "tick dropped", {49'd0, sub_cnt_o}, 64'd0);
      ticks(1, "R9");
      chk("R9", "resumes", {49'd0, sub_cnt_o}, 64'd1);

      // R10/R11 doubling with interval 0
      wr(3'd3, 32'd0, "R11");
      wr(3'd4, 32'hC000_0000, "R10");
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R10");
      ticks(4, "R10");
      chk("R10", "adoption boundary", {49'd0, sub_cnt_o}, 64'd1);
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R10");
      ticks(4, "R10");
      chk("R10", "doubled tick", {49'd0, sub_cnt_o}, 64'd2);
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R11");
      ticks(4, "R11");
      chk("R11", "every second", {49'd0, sub_cnt_o}, 64'd2);
      set_time(SMAX - 15'd2, 32'd0, 32'd0, "R11");
      ticks(3, "R11");
      set_time(15'd20, 32'd0, 32'd0, "R11");
      ticks(1, "R11");
      chk("R11", "commit cancels armed", {49'd0, sub_cnt_o}, 64'd21);

      // random mix checked against the model
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         r = $urandom % 100;
         if (r < 75) begin
            ticks(1, "R2/R3/R9/R10 random");
         end else if (r < 80) begin
            set_time(SMAX - 15'($urandom % 8), $urandom, $urandom % 4, "R5 random");
         end else if (r < 82) begin
            wr(3'($urandom % 2 + 3), ($urandom % 2 == 0) ? 32'd1 : ($urandom & 32'hC000_0003),
               "R7/R8 random");
         end else begin
            cyc(1'($urandom % 2), 1'b1, 1'($urandom % 2), 3'($urandom % 6),
                ($urandom % 2 == 0) ? {17'd0, SMAX} : $urandom, "R4/R6 random");
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule